// File: doc/BRIEF.md
# Host Access Bridge with Completion Interrupt

This block sits between a processor's register bus and the host management port of two MAC instances. The processor writes a command word that names the access kind, the target MAC and a host address. The bridge launches that access downstream as a one-cycle request and then keeps track of it until it finishes. Only one access can be outstanding at a time. A command word written while an access is still running is dropped without any trace.

Configuration and address-filter accesses finish on the cycle after their request. The serial management (MDIO) accesses take a variable time, so the bridge waits for a done strobe from the host side. Software can learn that an access has finished in two ways. It can poll a ready register, which holds one bit per access kind plus a single all-idle bit. Or it can rely on a level interrupt, driven from a write-one-to-clear status register whose bits only record a completion when the matching enable bit is set.

Top module: `host_access_bridge`

## Requirements
- R1: After reset, the ready register (0x3AC) reads 0x0000_803F, the interrupt enable (0x3B8) and status (0x3B4) registers read 0, `irq` is low and `host_req` is low.
- R2: A write to the command register 0x3A0 carries the kind code in bits [2:0], the MAC select in bit 4 and the host address in bits [25:16]. The command is accepted only when the bridge is idle and the kind code is 0 to 5. The kind codes are: 0 config read, 1 config write, 2 filter read, 3 filter write, 4 MDIO read, 5 MDIO write. One cycle after an accepted write, `host_req` is high for exactly one cycle, with the latched kind, MAC and address shown on the host outputs. Codes 6 and 7 are ignored.
- R3: A command written while an access is outstanding produces no request and leaves the latched host outputs unchanged.
- R4: The ready register bit at the position equal to the kind code reads 0 while that access is outstanding, and bit 15 reads 0 while any access is outstanding. Every one of these bits reads 1 again once the access completes.
- R5: Config and filter accesses complete on the clock edge after the request, with no done strobe. An MDIO access completes only on an edge where `host_done` is high. A `host_done` strobe that arrives while the bridge is idle has no effect.
- R6: When a read kind (0, 2, 4) completes, `host_rdata` is captured into the read register 0x3A8. Write kinds leave that register unchanged.
- R7: The MDIO data register 0x3B0 stores the low 16 bits written to it and reads 0 in bits [31:16]. An MDIO write drives that value, zero-extended, on `host_wdata`. Every other kind drives the 32-bit data register 0x3A4 on `host_wdata`.
- R8: On completion, status bit k (k = kind code) is set only if enable bit k is 1. A status bit whose enable bit is 0 keeps its value.
- R9: Writing 1 to a status bit at 0x3B4 clears it. When a set and a clear hit the same bit on the same edge, the set wins.
- R10: `irq` is the OR over all kinds of status AND enable. It is a level that stays high until software clears the status or the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register-bus write strobe |
| reg_addr | input | 10 | Register-bus address |
| reg_wdata | input | 32 | Register-bus write data |
| reg_rdata | output | 32 | Register-bus read data (combinational on reg_addr) |
| host_req | output | 1 | One-cycle access request toward the MAC host port |
| host_mac | output | 1 | Target MAC select |
| host_kind | output | 3 | Access kind code |
| host_addr | output | 10 | Host register address |
| host_wdata | output | 32 | Host write data |
| host_rdata | input | 32 | Host read data, valid at completion |
| host_done | input | 1 | Completion strobe for MDIO accesses |
| irq | output | 1 | Level completion interrupt, active high |

## Verification
The hardest case to reach from the ports is an edge on which two things happen at once: a completion tries to set a status bit, and a software write-one-to-clear tries to clear that same bit. A close second is a command that lands in the single cycle in which a config or filter access is still busy. The stimulus reaches both by starting the register write on the falling edge right after the request appears. This makes the write span exactly the completion edge. The same trick is used with `host_done` for MDIO kinds. Random traffic adds MDIO latencies from zero cycles upward and stray done strobes while idle. It also toggles the enables, so completions with the enable bit cleared are exercised as well.

// File: rtl/hab_pkg.sv
// Package: shared kind encoding and helpers for the host access bridge.
// Assumes kind codes double as bit positions in the ready and interrupt registers.
package hab_pkg;
    localparam int KIND_N = 6;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_CFG_RD  = 3'd0,
        K_CFG_WR  = 3'd1,
        K_FILT_RD = 3'd2,
        K_FILT_WR = 3'd3,
        K_MD_RD   = 3'd4,
        K_MD_WR   = 3'd5
    } kind_e;

    // True for a code that names a real access kind.
    function automatic logic kind_ok(input logic [KIND_W-1:0] k);
        return k < KIND_W'(KIND_N);
    endfunction

    // True for the two serial-management kinds (variable latency).
    function automatic logic kind_is_mdio(input logic [KIND_W-1:0] k);
        return (k == K_MD_RD) || (k == K_MD_WR);
    endfunction

    // True for kinds that return data.
    function automatic logic kind_is_read(input logic [KIND_W-1:0] k);
        return (k == K_CFG_RD) || (k == K_FILT_RD) || (k == K_MD_RD);
    endfunction
endpackage

// File: rtl/hab_cmd_ctrl.sv
// Command controller: accepts one command at a time, issues a one-cycle
// request, tracks the outstanding access and reports its completion.
// Assumes: config/filter kinds finish one edge after the request; MDIO kinds
// finish on host_done; commands arriving while busy are dropped.
module hab_cmd_ctrl
    import hab_pkg::*;
#(
    parameter int HADDR_W = 10,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we_i,
    input  logic [KIND_W-1:0]  cmd_kind_i,
    input  logic               cmd_mac_i,
    input  logic [HADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0]  cmd_wdata_i,
    input  logic               host_done_i,
    output logic               host_req_o,
    output logic [KIND_W-1:0]  host_kind_o,
    output logic               host_mac_o,
    output logic [HADDR_W-1:0] host_addr_o,
    output logic [DATA_W-1:0]  host_wdata_o,
    output logic               finish_o,
    output logic [KIND_N-1:0]  ready_o,
    output logic               idle_o
);
    logic busy_q;
    logic accept;

    assign accept   = cmd_we_i && !busy_q && kind_ok(cmd_kind_i);
    assign finish_o = busy_q && (kind_is_mdio(host_kind_o) ? host_done_i : 1'b1);
    assign idle_o   = !busy_q;

    // Busy flag and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            host_req_o <= 1'b0;
        end else begin
            host_req_o <= accept;
            if (accept)
                busy_q <= 1'b1;
            else if (finish_o)
                busy_q <= 1'b0;
        end
    end

    // Latch the command fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_kind_o  <= '0;
            host_mac_o   <= 1'b0;
            host_addr_o  <= '0;
            host_wdata_o <= '0;
        end else if (accept) begin
            host_kind_o  <= cmd_kind_i;
            host_mac_o   <= cmd_mac_i;
            host_addr_o  <= cmd_addr_i;
            host_wdata_o <= cmd_wdata_i;
        end
    end

    // Per-kind ready bits: low only for the kind in flight.
    for (genvar i = 0; i < KIND_N; i++) begin : g_rdy
        assign ready_o[i] = !(busy_q && (host_kind_o == KIND_W'(i)));
    end

    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_o |=> !host_req_o);
    // R3
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && cmd_we_i) |=> (!host_req_o && $stable(host_kind_o) && $stable(host_addr_o)));
    // R4
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_o |-> (!idle_o && ($countones(ready_o) == KIND_N - 1)));
    // R5
    quick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req_o && !kind_is_mdio(host_kind_o)) |=> (idle_o && (&ready_o)));
    // R5
    mdio_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && kind_is_mdio(host_kind_o) && !host_done_i) |=> !idle_o);
endmodule

// File: rtl/hab_irq.sv
// Interrupt block: enable register, write-one-to-clear status register and
// the level interrupt output. Assumes a completion and a clear may meet on
// the same edge; the completion wins.
module hab_irq
    import hab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we_i,
    input  logic              clr_we_i,
    input  logic [KIND_N-1:0] wdata_i,
    input  logic              finish_i,
    input  logic [KIND_W-1:0] fin_kind_i,
    output logic [KIND_N-1:0] en_o,
    output logic [KIND_N-1:0] stat_o,
    output logic              irq_o
);
    logic [KIND_N-1:0] set_vec;
    logic [KIND_N-1:0] clr_vec;

    assign clr_vec = clr_we_i ? wdata_i : '0;
    assign irq_o   = |(stat_o & en_o);

    // Set request per kind, gated by its enable bit.
    for (genvar i = 0; i < KIND_N; i++) begin : g_set
        assign set_vec[i] = finish_i && (fin_kind_i == KIND_W'(i)) && en_o[i];

        // R8
        masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_o[i] && !clr_vec[i]) |=> $stable(stat_o[i]));
        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> stat_o[i]);
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_o <= '0;
        else if (en_we_i)
            en_o <= wdata_i;
    end

    // Status register: clear first, then set, so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_o <= '0;
        else
            stat_o <= (stat_o & ~clr_vec) | set_vec;
    end

    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_we_i && !en_we_i) |=> irq_o);
endmodule

// File: rtl/host_access_bridge.sv
// Top: register decode, data registers and read mux around the command
// controller and interrupt block. Assumes a single processor master and
// combinational reads; the MDIO data register has no reset value.
module host_access_bridge
    import hab_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int HADDR_W = 10,
    parameter int MDIO_W  = 16,
    parameter logic [ADDR_W-1:0] A_CMD   = 10'h3A0,
    parameter logic [ADDR_W-1:0] A_GDATA = 10'h3A4,
    parameter logic [ADDR_W-1:0] A_RDBUF = 10'h3A8,
    parameter logic [ADDR_W-1:0] A_READY = 10'h3AC,
    parameter logic [ADDR_W-1:0] A_MDIO  = 10'h3B0,
    parameter logic [ADDR_W-1:0] A_STAT  = 10'h3B4,
    parameter logic [ADDR_W-1:0] A_EN    = 10'h3B8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               host_req,
    output logic               host_mac,
    output logic [KIND_W-1:0]  host_kind,
    output logic [HADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0]  host_wdata,
    input  logic [DATA_W-1:0]  host_rdata,
    input  logic               host_done,
    output logic               irq
);
    localparam int KIND_LSB  = 0;
    localparam int MAC_BIT   = 4;
    localparam int HADDR_LSB = 16;
    localparam int IDLE_BIT  = 15;

    logic [MDIO_W-1:0]  mdio_q;
    logic [DATA_W-1:0]  gdata_q;
    logic [DATA_W-1:0]  rdbuf_q;
    logic [KIND_W-1:0]  cmd_kind;
    logic [DATA_W-1:0]  cmd_wdata;
    logic               finish;
    logic               idle;
    logic [KIND_N-1:0]  ready;
    logic [KIND_N-1:0]  irq_en;
    logic [KIND_N-1:0]  irq_stat;

    assign cmd_kind  = reg_wdata[KIND_LSB +: KIND_W];
    assign cmd_wdata = (cmd_kind == K_MD_WR) ? DATA_W'(mdio_q) : gdata_q;

    // MDIO write data: no reset, defined only once software writes it.
    always_ff @(posedge clk) begin
        if (reg_wr && (reg_addr == A_MDIO))
            mdio_q <= reg_wdata[MDIO_W-1:0];
    end

    // General write data register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gdata_q <= '0;
        else if (reg_wr && (reg_addr == A_GDATA))
            gdata_q <= reg_wdata;
    end

    // Capture returned data when a read kind completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdbuf_q <= '0;
        else if (finish && kind_is_read(host_kind))
            rdbuf_q <= host_rdata;
    end

    hab_cmd_ctrl #(.HADDR_W(HADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we_i     (reg_wr && (reg_addr == A_CMD)),
        .cmd_kind_i   (cmd_kind),
        .cmd_mac_i    (reg_wdata[MAC_BIT]),
        .cmd_addr_i   (reg_wdata[HADDR_LSB +: HADDR_W]),
        .cmd_wdata_i  (cmd_wdata),
        .host_done_i  (host_done),
        .host_req_o   (host_req),
        .host_kind_o  (host_kind),
        .host_mac_o   (host_mac),
        .host_addr_o  (host_addr),
        .host_wdata_o (host_wdata),
        .finish_o     (finish),
        .ready_o      (ready),
        .idle_o       (idle)
    );

    hab_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we_i    (reg_wr && (reg_addr == A_EN)),
        .clr_we_i   (reg_wr && (reg_addr == A_STAT)),
        .wdata_i    (reg_wdata[KIND_N-1:0]),
        .finish_i   (finish),
        .fin_kind_i (host_kind),
        .en_o       (irq_en),
        .stat_o     (irq_stat),
        .irq_o      (irq)
    );

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MDIO:  reg_rdata[MDIO_W-1:0] = mdio_q;
            A_GDATA: reg_rdata = gdata_q;
            A_RDBUF: reg_rdata = rdbuf_q;
            A_READY: begin
                reg_rdata[KIND_N-1:0] = ready;
                reg_rdata[IDLE_BIT]   = idle;
            end
            A_STAT:  reg_rdata[KIND_N-1:0] = irq_stat;
            A_EN:    reg_rdata[KIND_N-1:0] = irq_en;
            default: reg_rdata = '0;
        endcase
    end

    // R6
    rdbuf_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && kind_is_read(host_kind)) |=> (rdbuf_q == $past(host_rdata)));
    // R7
    mdio_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && (host_kind == K_MD_WR)) |-> (host_wdata[DATA_W-1:MDIO_W] == '0));
endmodule

// File: tb/sim_host_access_bridge.sv
module sim_host_access_bridge;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] A_CMD = 10'h3A0, A_GDATA = 10'h3A4, A_RDBUF = 10'h3A8,
                           A_READY = 10'h3AC, A_MDIO = 10'h3B0, A_STAT = 10'h3B4,
                           A_EN = 10'h3B8;
    localparam logic [31:0] IDLE_RDY = 32'h0000_803F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_req, host_mac, host_done = 1'b0, irq;
    logic [2:0]  host_kind;
    logic [9:0]  host_addr;
    logic [31:0] host_wdata, host_rdata = '0;

    int nchk = 0, nfail = 0;
    bit done_flag = 0;
    logic [5:0]  exp_en = '0, exp_stat = '0;
    logic [31:0] exp_rd = '0, exp_gdata = '0;
    logic [15:0] exp_mdio = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_access_bridge u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_req(host_req),
        .host_mac(host_mac), .host_kind(host_kind), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_done(host_done),
        .irq(irq)
    );

    function automatic logic [31:0] hostval(input logic m, input logic [2:0] k, input logic [9:0] a);
        return {7'h5A, m, 2'b00, k, 9'h000, a} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] busy_rdy(input logic [2:0] k);
        return 32'h0000_003F & ~(32'h1 << k);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Caller stands at a falling edge; returns at the next one.
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_idle_state(input string req);
        logic [31:0] v;
        rd(A_READY, v); chk({req, " R4 ready idle"}, v, IDLE_RDY);
        rd(A_STAT, v);  chk({req, " R8 stat"}, v, 32'(exp_stat));
        chk({req, " R10 irq"}, 32'(irq), 32'(|(exp_stat & exp_en)));
        rd(A_RDBUF, v); chk({req, " R6 rdbuf"}, v, exp_rd);
    endtask

    // mode: 0 quiet, 1 poke commands while busy, 2 W1C on the completion edge
    task automatic access(input logic [2:0] k, input logic m, input logic [9:0] a,
                          input int delay, input int mode);
        logic [31:0] v;
        bit md = (k == 3'd4) || (k == 3'd5);
        host_rdata = hostval(m, k, a);
        wr(A_CMD, (32'(a) << 16) | (32'(m) << 4) | 32'(k));
        if (k > 3'd5) begin
            chk("R2 bad kind no req", 32'(host_req), 32'h0);
            rd(A_READY, v); chk("R2 bad kind ready", v, IDLE_RDY);
            return;
        end
        chk("R2 req", 32'(host_req), 32'h1);
        chk("R2 kind", 32'(host_kind), 32'(k));
        chk("R2 mac", 32'(host_mac), 32'(m));
        chk("R2 addr", 32'(host_addr), 32'(a));
        chk("R7 wdata", host_wdata, (k == 3'd5) ? 32'(exp_mdio) : exp_gdata);
        rd(A_READY, v); chk("R4 busy ready", v, busy_rdy(k));
        if (!md) begin
            if (mode == 1) begin
                wr(A_CMD, 32'h0000_0003);
                chk("R3 no req", 32'(host_req), 32'h0);
                chk("R3 kind kept", 32'(host_kind), 32'(k));
            end else if (mode == 2) begin
                wr(A_STAT, 32'h3F);
                exp_stat = '0;
            end else begin
                @(negedge clk);
            end
        end else begin
            for (int i = 0; i < delay; i++) begin
                if (mode == 1) wr(A_CMD, 32'h0001_0011);
                else @(negedge clk);
                chk("R3 no req while busy", 32'(host_req), 32'h0);
                chk("R3 addr kept", 32'(host_addr), 32'(a));
            end
            rd(A_READY, v); chk("R5 mdio waits", v, busy_rdy(k));
            host_done = 1'b1;
            if (mode == 2) begin
                wr(A_STAT, 32'h3F);
                exp_stat = '0;
            end else begin
                @(negedge clk);
            end
            host_done = 1'b0;
        end
        if (exp_en[k]) exp_stat[k] = 1'b1;
        if (!k[0]) exp_rd = hostval(m, k, a);
        check_idle_state("done");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_READY, v); chk("R1 ready", v, IDLE_RDY);
        rd(A_EN, v);    chk("R1 en", v, 32'h0);
        rd(A_STAT, v);  chk("R1 stat", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 req", 32'(host_req), 32'h0);

        // R7 MDIO data register readback, upper bits zero
        wr(A_MDIO, 32'hDEAD_BEEF); exp_mdio = 16'hBEEF;
        rd(A_MDIO, v); chk("R7 mdio readback", v, 32'h0000_BEEF);
        wr(A_GDATA, 32'h0123_4567); exp_gdata = 32'h0123_4567;

        // R8 disabled completion leaves status alone
        access(3'd0, 1'b0, 10'h011, 0, 0);
        // R10 enabled completion raises irq, stays until cleared
        wr(A_EN, 32'h3F); exp_en = 6'h3F;
        access(3'd1, 1'b1, 10'h222, 0, 0);
        @(negedge clk); @(negedge clk);
        chk("R10 irq held", 32'(irq), 32'h1);
        wr(A_STAT, 32'h02); exp_stat[1] = 1'b0;
        chk("R9 w1c clears irq", 32'(irq), 32'h0);
        // R9 set wins over simultaneous clear
        access(3'd2, 1'b0, 10'h033, 0, 2);
        access(3'd4, 1'b1, 10'h3FF, 0, 2);
        // R3 commands while busy
        access(3'd3, 1'b1, 10'h155, 0, 1);
        access(3'd5, 1'b0, 10'h0AA, 5, 1);
        // R5 stray done while idle
        host_done = 1'b1; @(negedge clk); host_done = 1'b0;
        check_idle_state("R5 stray done");
        // R2 invalid kinds
        access(3'd6, 1'b0, 10'h001, 0, 0);
        access(3'd7, 1'b1, 10'h002, 0, 0);

        // random mix
        for (int n = 0; n < 120; n++) begin
            if ($urandom % 4 == 0) begin
                v = $urandom; wr(A_EN, v); exp_en = v[5:0];
                rd(A_EN, v); chk("R8 en readback", v, 32'(exp_en));
            end
            if ($urandom % 5 == 0) begin
                v = $urandom; wr(A_STAT, v); exp_stat = exp_stat & ~v[5:0];
            end
            if ($urandom % 3 == 0) begin v = $urandom; wr(A_GDATA, v); exp_gdata = v; end
            if ($urandom % 3 == 0) begin v = $urandom; wr(A_MDIO, v); exp_mdio = v[15:0]; end
            if ($urandom % 8 == 0) begin
                host_done = 1'b1; @(negedge clk); host_done = 1'b0;
                check_idle_state("R5 stray done rnd");
            end
            access(3'($urandom % 8), 1'($urandom), 10'($urandom), int'($urandom % 13),
                   int'($urandom % 3));
        end

        done_flag = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule